// File: doc/BRIEF.md
# Clock-loss sync reset controller

This block guards an audio datapath against loss of clock synchronisation. It watches a lock indication from the clocking logic. When lock drops, it forces every sample leaving the block to digital zero. It also sends a one-cycle pulse that wipes the stored DC-offset calibration values. The block then stays in this guarded condition until the lock indication has held steady for a programmable number of cycles.

Two enable inputs, supplied by configuration registers that live elsewhere, select an optional hard-mute path. When both are set at the moment sync is lost, the block raises a mute flag. After the clocks settle, it asks the calibration engine to run and keeps the mute flag up until that engine reports completion. The external active-low reset is the only input that returns the block to its start state. A loss of sync never touches configuration, which this block does not hold.

Top module: `clkloss_sync_ctrl`

## Requirements
- R1: While `zero_sel_o` is high, every bit of `sample_o` is 0. While it is low, `sample_o` equals `sample_i` in the same cycle.
- R2: When `lock_i` is sampled low at a clock edge while `zero_sel_o` is low, `zero_sel_o` is high in the following cycle.
- R3: `cal_clear_o` is high for exactly the one cycle after the edge that detects the loss. It does not fire again while the loss persists, during the settling wait, or on a lock glitch inside that wait.
- R4: After a loss, `zero_sel_o` falls only after the edge following `STABLE_CYCLES` consecutive edges at which `lock_i` was high. If `lock_i` is high at edges f through f+`STABLE_CYCLES`, the output is low after edge f+`STABLE_CYCLES`. Any edge with `lock_i` low restarts the count.
- R5: Hard mute applies only if `cfg_arm_i` and `cfg_hard_mute_i` are both 1 at the edge that detects the loss. Changing them afterwards has no effect on that episode. When it applies, `mute_o` is high from the cycle after that edge.
- R6: With hard mute applied, `cal_req_o` rises at the same edge at which `zero_sel_o` falls, while `mute_o` stays high. When `cal_done_i` is sampled high with `cal_req_o` high and lock present, both `mute_o` and `cal_req_o` are low in the next cycle.
- R7: `cal_done_i` has no effect while `cal_req_o` is low. In particular, it does not clear `mute_o`.
- R8: Without hard mute, `mute_o` and `cal_req_o` stay low for the whole episode, and samples pass again as soon as R4 releases.
- R9: After `rst_n` is released, the outputs are `zero_sel_o`=1, `mute_o`=0, `cal_req_o`=0 and `cal_clear_o`=0. Samples first pass under the R4 rule.
- R10: A lock loss while calibration is requested drops `cal_req_o`, issues a new clear pulse and keeps `mute_o` high. Calibration is requested again after the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | External active-low reset |
| lock_i | input | 1 | Clock lock indication, 1 = synchronised |
| cfg_arm_i | input | 1 | Enable that gates the hard-mute option |
| cfg_hard_mute_i | input | 1 | Hard mute with recalibration on sync loss |
| cal_done_i | input | 1 | Calibration engine finished |
| sample_i | input | NUM_CH*SAMPLE_W | Incoming channel samples |
| sample_o | output | NUM_CH*SAMPLE_W | Samples to the datapath, zero while guarded |
| zero_sel_o | output | 1 | Zero-substitution select |
| cal_clear_o | output | 1 | One-cycle pulse clearing DC-offset values |
| mute_o | output | 1 | Hard-mute flag |
| cal_req_o | output | 1 | Auto-calibration request |

## Verification
Every episode is driven through all four settings of the two enable bits. The enable bits are then forced to 1 just after the loss, which separates mute decided at the loss edge from mute that follows the live bits. Each episode also carries a lock glitch at every position from none up to exactly `STABLE_CYCLES` high edges. This exposes an off-by-one in the settling count, a count that does not restart, and a spurious clear pulse inside the wait. A calibration-done pulse during the loss, and a second loss in the middle of calibration, separate a mute that clears only on a real completion from one that clears on any done pulse.

// File: rtl/clkloss_pkg.sv
package clkloss_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_LOST = 2'd1,
    ST_WAIT = 2'd2,
    ST_CAL  = 2'd3
  } sync_state_e;

  // both enables must be set for the hard-mute option to take hold
  function automatic logic hard_mute_active(input logic arm, input logic hm);
    return arm & hm;
  endfunction

  // bits needed to hold a count of 0..limit
  function automatic int unsigned count_width(input int unsigned limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/clkloss_lock_filter.sv
module clkloss_lock_filter
  import clkloss_pkg::*;
#(
  parameter int unsigned STABLE_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  output logic stable_o
);

  localparam int unsigned CNT_W = count_width(STABLE_CYCLES);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STABLE_CYCLES);

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!lock_i) begin
      run_q <= '0;
    end else if (run_q != LIMIT) begin
      run_q <= run_q + CNT_W'(1);
    end
  end

  assign stable_o = (run_q == LIMIT);

endmodule

// File: rtl/clkloss_fsm.sv
module clkloss_fsm
  import clkloss_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  input  logic stable_i,
  input  logic cfg_arm_i,
  input  logic cfg_hard_mute_i,
  input  logic cal_done_i,
  output logic zero_sel_o,
  output logic cal_clear_o,
  output logic mute_o,
  output logic cal_req_o,
  output logic enter_lost_o,
  output logic release_o,
  output logic cal_finish_o
);

  sync_state_e state_q, state_d;
  logic        mute_q;
  logic        clear_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (!lock_i) state_d = ST_LOST;
      ST_LOST: if (lock_i)  state_d = ST_WAIT;
      ST_WAIT: if (stable_i && lock_i) state_d = mute_q ? ST_CAL : ST_RUN;
      ST_CAL: begin
        if (!lock_i)         state_d = ST_LOST;
        else if (cal_done_i) state_d = ST_RUN;
      end
      default: state_d = ST_WAIT;
    endcase
  end

  assign enter_lost_o = (state_d == ST_LOST) && (state_q != ST_LOST);
  assign release_o    = (state_q == ST_WAIT) && (state_d != ST_WAIT);
  assign cal_finish_o = (state_q == ST_CAL) && lock_i && cal_done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      mute_q  <= 1'b0;
      clear_q <= 1'b0;
    end else begin
      state_q <= state_d;
      clear_q <= enter_lost_o;
      if (enter_lost_o) begin
        mute_q <= mute_q | hard_mute_active(cfg_arm_i, cfg_hard_mute_i);
      end else if (cal_finish_o) begin
        mute_q <= 1'b0;
      end
    end
  end

  assign zero_sel_o  = (state_q == ST_LOST) || (state_q == ST_WAIT);
  assign cal_clear_o = clear_q;
  assign mute_o      = mute_q;
  assign cal_req_o   = (state_q == ST_CAL);

endmodule

// File: rtl/clkloss_sample_gate.sv
module clkloss_sample_gate #(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                       zero_sel_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] sample_i,
  output logic [NUM_CH*SAMPLE_W-1:0] sample_o
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign sample_o[ch*SAMPLE_W +: SAMPLE_W] =
      zero_sel_i ? '0 : sample_i[ch*SAMPLE_W +: SAMPLE_W];
  end

endmodule

// File: rtl/clkloss_sync_ctrl.sv
module clkloss_sync_ctrl
  import clkloss_pkg::*;
#(
  parameter int unsigned NUM_CH        = 2,
  parameter int unsigned SAMPLE_W      = 24,
  parameter int unsigned STABLE_CYCLES = 1024
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lock_i,
  input  logic                       cfg_arm_i,
  input  logic                       cfg_hard_mute_i,
  input  logic                       cal_done_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] sample_i,
  output logic [NUM_CH*SAMPLE_W-1:0] sample_o,
  output logic                       zero_sel_o,
  output logic                       cal_clear_o,
  output logic                       mute_o,
  output logic                       cal_req_o
);

  logic stable;
  logic enter_lost;
  logic release_ev;
  logic cal_finish;

  clkloss_lock_filter #(
    .STABLE_CYCLES(STABLE_CYCLES)
  ) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_i  (lock_i),
    .stable_o(stable)
  );

  clkloss_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .lock_i         (lock_i),
    .stable_i       (stable),
    .cfg_arm_i      (cfg_arm_i),
    .cfg_hard_mute_i(cfg_hard_mute_i),
    .cal_done_i     (cal_done_i),
    .zero_sel_o     (zero_sel_o),
    .cal_clear_o    (cal_clear_o),
    .mute_o         (mute_o),
    .cal_req_o      (cal_req_o),
    .enter_lost_o   (enter_lost),
    .release_o      (release_ev),
    .cal_finish_o   (cal_finish)
  );

  clkloss_sample_gate #(
    .NUM_CH  (NUM_CH),
    .SAMPLE_W(SAMPLE_W)
  ) u_gate (
    .zero_sel_i(zero_sel_o),
    .sample_i  (sample_i),
    .sample_o  (sample_o)
  );

endmodule

// File: rtl/clkloss_sync_ctrl_chk.sv
module clkloss_sync_ctrl_chk #(
  parameter int unsigned DATA_W        = 48,
  parameter int unsigned STABLE_CYCLES = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lock_i,
  input logic              cal_done_i,
  input logic              release_ev,
  input logic [DATA_W-1:0] sample_o,
  input logic              zero_sel_o,
  input logic              cal_clear_o,
  input logic              mute_o,
  input logic              cal_req_o
);

  localparam int unsigned RW = $clog2(STABLE_CYCLES + 2) + 1;
  localparam logic [RW-1:0] TOP = RW'(STABLE_CYCLES + 1);

  logic [RW-1:0] lock_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lock_run_q <= '0;
    else if (!lock_i)         lock_run_q <= '0;
    else if (lock_run_q != TOP) lock_run_q <= lock_run_q + RW'(1);
  end

  AST_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    zero_sel_o |-> (sample_o == '0)); // R1

  AST_LOSS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_i && !zero_sel_o) |=> (zero_sel_o && cal_clear_o)); // R2

  AST_CLEAR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_clear_o |=> !cal_clear_o); // R3

  AST_NO_CLEAR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_sel_o && !cal_clear_o) |=> !cal_clear_o); // R3

  AST_SETTLED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zero_sel_o) |-> (lock_run_q >= RW'(STABLE_CYCLES))); // R4

  AST_RELEASE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |=> !zero_sel_o); // R4

  AST_REQ_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req_o |-> (mute_o && !zero_sel_o)); // R6

  AST_MUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_o && !(cal_req_o && cal_done_i && lock_i)) |=> mute_o); // R7

endmodule

bind clkloss_sync_ctrl clkloss_sync_ctrl_chk #(
  .DATA_W       (NUM_CH * SAMPLE_W),
  .STABLE_CYCLES(STABLE_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lock_i     (lock_i),
  .cal_done_i (cal_done_i),
  .release_ev (release_ev),
  .sample_o   (sample_o),
  .zero_sel_o (zero_sel_o),
  .cal_clear_o(cal_clear_o),
  .mute_o     (mute_o),
  .cal_req_o  (cal_req_o)
);

// File: tb/clkloss_sync_ctrl_bench.sv
`timescale 1ns/1ps
module clkloss_sync_ctrl_bench;

  localparam int unsigned NCH = 2;
  localparam int unsigned SW  = 24;
  localparam int unsigned N   = 8;
  localparam int unsigned DW  = NCH * SW;

  logic clk = 1'b0;
  logic rst_n, lock, arm, hm, cal_done;
  logic [DW-1:0] sample_i, sample_o;
  logic zero_sel, cal_clear, mute, cal_req;

  int nchecks = 0;
  int nerrs   = 0;

  always #4 clk = ~clk;

  clkloss_sync_ctrl #(
    .NUM_CH(NCH), .SAMPLE_W(SW), .STABLE_CYCLES(N)
  ) u_clkloss_sync_ctrl (
    .clk(clk), .rst_n(rst_n), .lock_i(lock), .cfg_arm_i(arm),
    .cfg_hard_mute_i(hm), .cal_done_i(cal_done), .sample_i(sample_i),
    .sample_o(sample_o), .zero_sel_o(zero_sel), .cal_clear_o(cal_clear),
    .mute_o(mute), .cal_req_o(cal_req)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerrs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic zs, input logic cc,
                            input logic mu, input logic cr);
    chk(req, "zero_sel", 64'(zero_sel), 64'(zs));
    chk(req, "cal_clear", 64'(cal_clear), 64'(cc));
    chk(req, "mute", 64'(mute), 64'(mu));
    chk(req, "cal_req", 64'(cal_req), 64'(cr));
  endtask

  task automatic chk_data(input string req);
    #1;
    chk(req, "sample_o", 64'(sample_o), zero_sel ? 64'd0 : 64'(sample_i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerrs++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lock = 1'b0; arm = 1'b0; hm = 1'b0; cal_done = 1'b0;
    sample_i = 48'h123456_654321;
    repeat (3) tick();
    expect_out("R9", 1'b1, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    tick();
    expect_out("R9", 1'b1, 1'b0, 1'b0, 1'b0);
    chk_data("R1");
    lock = 1'b1;
    repeat (N) tick();
    chk("R9", "zero_sel before settle", 64'(zero_sel), 64'd1);
    tick();
    expect_out("R9", 1'b0, 1'b0, 1'b0, 1'b0);
    chk_data("R1");

    for (int combo = 0; combo < 4; combo++) begin
      for (int k = 0; k <= int'(N); k++) begin
        logic eff;
        arm = combo[1]; hm = combo[0];
        eff = combo[1] & combo[0];
        sample_i = {24'(k * 37 + combo + 1), 24'(combo * 5 + k + 1)};
        chk_data("R1");
        // loss detected at the next edge
        lock = 1'b0;
        tick();
        expect_out("R2", 1'b1, 1'b1, eff, 1'b0);
        chk("R5", "mute at loss", 64'(mute), 64'(eff));
        chk_data("R1");
        // enables change after the loss edge; done pulse while lost
        arm = 1'b1; hm = 1'b1; cal_done = 1'b1;
        tick();
        cal_done = 1'b0;
        expect_out("R7", 1'b1, 1'b0, eff, 1'b0);
        tick();
        chk("R3", "clear while lost", 64'(cal_clear), 64'd0);
        if (k > 0) begin
          lock = 1'b1;
          repeat (k) tick();
          chk("R4", "zero_sel during glitch wait", 64'(zero_sel), 64'd1);
          lock = 1'b0;
          tick();
          expect_out("R4", 1'b1, 1'b0, eff, 1'b0);
        end
        lock = 1'b1;
        repeat (N) tick();
        chk("R4", "zero_sel one edge short", 64'(zero_sel), 64'd1);
        chk("R3", "clear during wait", 64'(cal_clear), 64'd0);
        tick();
        if (eff) begin
          expect_out("R6", 1'b0, 1'b0, 1'b1, 1'b1);
          repeat (2) tick();
          chk("R6", "cal_req held", 64'(cal_req), 64'd1);
          if (k == 1) begin
            lock = 1'b0;
            tick();
            expect_out("R10", 1'b1, 1'b1, 1'b1, 1'b0);
            lock = 1'b1;
            repeat (N + 1) tick();
            expect_out("R10", 1'b0, 1'b0, 1'b1, 1'b1);
          end
          cal_done = 1'b1;
          tick();
          cal_done = 1'b0;
          expect_out("R6", 1'b0, 1'b0, 1'b0, 1'b0);
        end else begin
          expect_out("R8", 1'b0, 1'b0, 1'b0, 1'b0);
        end
        chk_data("R1");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end

endmodule